// File: doc/BRIEF.md
# SPI Chip-Select Expander

This block lets a host with only two spare SPI select lines reach many SPI devices spread over a stack of cards that share one SPI bus. One select line is a setup strobe. While it is low, the host clocks an 8-bit selection byte into the block. The top two bits of that byte name a card, and the low four bits name a device on that card. The other select line is an access strobe. Once a selection is held, every low period of the access strobe is steered onto exactly one device select of the chosen card. The selection then stays in place for as many transfers as the host wants.

Each card reads its own 2-bit identity from jumpers. A card whose identity differs from the selection byte keeps all of its device selects high. Nine selects leave the block for external devices. Two more stay on chip for local register blocks.

The SPI signals are taken as inputs synchronous to the block clock. The block detects SCLK edges and strobe edges by comparing each signal with its registered copy.

Top module: `spx_expander`

## Requirements
- R1: After reset, and until a complete selection byte has been received, every device select is high, even while the access strobe is low.
- R2: While the setup strobe is low, the bit on `sdi` is captured at each rising SCLK edge, most significant bit first. The selection byte has this layout: bits 7:6 are the card field, bits 5:4 are ignored, and bits 3:0 are the device index.
- R3: A device select can go low only when the card field equals `card_id`.
- R4: Index values 0 to 8 drive `ext_sel_n[index]` low. Index 9 drives `local_sel_n[0]` low and index 10 drives `local_sel_n[1]` low.
- R5: Index values 11 to 15 drive no select low.
- R6: The chosen select is low exactly while `access_n` is low, with no clock of delay, and it returns high as soon as `access_n` rises.
- R7: A held selection serves any number of access strobes, until the setup strobe is asserted again.
- R8: While `setup_n` is low, every device select is high, whatever the level of `access_n`.
- R9: A setup period with fewer than eight SCLK rises leaves no device selected. A setup period with more than eight rises keeps the last eight bits received.
- R10: At most one device select is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; SPI inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| card_id | input | 2 | Jumper identity of this card |
| sclk | input | 1 | SPI serial clock |
| sdi | input | 1 | SPI serial data from the host |
| setup_n | input | 1 | Active-low strobe framing the selection byte |
| access_n | input | 1 | Active-low strobe routed to the selected device |
| ext_sel_n | output | 9 | Active-low selects for external devices, indices 0 to 8 |
| local_sel_n | output | 2 | Active-low selects for on-chip devices, indices 9 and 10 |

## Verification
The assertions assume that every SPI input is already synchronous to `clk`. They also assume that each SCLK level lasts at least one clock, so that every rising edge is seen once, and that `setup_n` changes only while SCLK is low. The stimulus holds each SCLK level for two clocks and moves the strobes only with SCLK low. It changes inputs one time unit after a rising edge. The stimulus covers access strobes held low through a whole setup period, short and over-long selection bytes, and bytes addressed to other cards.

// File: rtl/spx_pkg.sv
package spx_pkg;
  parameter int unsigned SPX_BYTE_W = 8;
  parameter int unsigned SPX_CARD_W = 2;
  parameter int unsigned SPX_IDX_W  = 4;
  parameter int unsigned SPX_N_EXT   = 9;
  parameter int unsigned SPX_N_LOCAL = 2;
endpackage

// File: rtl/spx_rst_sync.sv
module spx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/spx_shift.sv
module spx_shift
  import spx_pkg::*;
#(
  parameter int unsigned BYTE_W = SPX_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              setup_n,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_ok
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic              sclk_q, setup_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_base;
  logic [BYTE_W-1:0] byte_d;
  logic              ok_d;
  logic              sclk_rise, setup_fall, setup_rise, shift_en;

  // edge detection and next state
  always_comb begin
    sclk_rise  = sclk & ~sclk_q;
    setup_fall = ~setup_n & setup_q;
    setup_rise = setup_n & ~setup_q;
    shift_en   = ~setup_n & sclk_rise;

    cnt_base = setup_fall ? '0 : cnt_q;
    cnt_d    = cnt_base;
    if (shift_en && (cnt_base != CNT_FULL)) cnt_d = cnt_base + 1'b1;

    byte_d = {byte_q[BYTE_W-2:0], sdi};

    ok_d = byte_ok;
    if (!setup_n)        ok_d = 1'b0;
    else if (setup_rise) ok_d = (cnt_q == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      setup_q <= 1'b1;
      cnt_q   <= '0;
      byte_q  <= '0;
      byte_ok <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      setup_q <= setup_n;
      cnt_q   <= cnt_d;
      if (shift_en) byte_q <= byte_d;
      byte_ok <= ok_d;
    end
  end

  // R2: newest bit lands in the low position
  assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (byte_q[0] == $past(sdi)))
    else $error("R2 shift order broken");

  // R9: counter saturates at a full byte
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL)
    else $error("R9 bit counter overflow");

  // R9: a selection becomes valid only after a full byte
  assert_full_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_ok) |-> ($past(cnt_q) == CNT_FULL))
    else $error("R9 short byte accepted");

  // R8: setup strobe withdraws the selection on the next edge
  assert_setup_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_n && setup_q) |=> !byte_ok)
    else $error("R8 selection kept during setup");
endmodule

// File: rtl/spx_demux.sv
module spx_demux #(
  parameter int unsigned N_DEV  = 11,
  parameter int unsigned CARD_W = 2,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [CARD_W-1:0] card,
  input  logic [CARD_W-1:0] card_id,
  input  logic [IDX_W-1:0]  idx,
  input  logic              byte_ok,
  input  logic              setup_n,
  input  logic              access_n,
  output logic [N_DEV-1:0]  dev_sel_n
);
  logic hit;

  always_comb begin
    hit = byte_ok & setup_n & ~access_n & (card == card_id);
  end

  for (genvar g = 0; g < N_DEV; g++) begin : g_sel
    assign dev_sel_n[g] = ~(hit && (idx == IDX_W'(g)));
  end
endmodule

// File: rtl/spx_expander.sv
module spx_expander
  import spx_pkg::*;
#(
  parameter int unsigned N_EXT   = SPX_N_EXT,
  parameter int unsigned N_LOCAL = SPX_N_LOCAL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SPX_CARD_W-1:0] card_id,
  input  logic                  sclk,
  input  logic                  sdi,
  input  logic                  setup_n,
  input  logic                  access_n,
  output logic [N_EXT-1:0]      ext_sel_n,
  output logic [N_LOCAL-1:0]    local_sel_n
);
  localparam int unsigned N_DEV = N_EXT + N_LOCAL;

  logic                  rst_sync_n;
  logic [SPX_BYTE_W-1:0] byte_q;
  logic                  byte_ok;
  logic [SPX_CARD_W-1:0] card;
  logic [SPX_IDX_W-1:0]  idx;
  logic [N_DEV-1:0]      dev_n;

  spx_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  spx_shift #(.BYTE_W(SPX_BYTE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sclk    (sclk),
    .sdi     (sdi),
    .setup_n (setup_n),
    .byte_q  (byte_q),
    .byte_ok (byte_ok)
  );

  assign card = byte_q[SPX_BYTE_W-1 -: SPX_CARD_W];
  assign idx  = byte_q[SPX_IDX_W-1:0];

  spx_demux #(.N_DEV(N_DEV), .CARD_W(SPX_CARD_W), .IDX_W(SPX_IDX_W)) u_demux (
    .card      (card),
    .card_id   (card_id),
    .idx       (idx),
    .byte_ok   (byte_ok),
    .setup_n   (setup_n),
    .access_n  (access_n),
    .dev_sel_n (dev_n)
  );

  assign ext_sel_n   = dev_n[N_EXT-1:0];
  assign local_sel_n = dev_n[N_DEV-1:N_EXT];

  assert_one_sel_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(~dev_n))
    else $error("R10 several selects low");

  assert_idle_access_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    access_n |-> (&dev_n))
    else $error("R6 select low without access");

  assert_setup_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !setup_n |-> (&dev_n))
    else $error("R8 select low during setup");

  assert_card_gate_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (card != card_id) |-> (&dev_n))
    else $error("R3 foreign card selected");

  assert_high_idx_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(idx) >= N_DEV) |-> (&dev_n))
    else $error("R5 undecoded index selected");

  assert_no_byte_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !byte_ok |-> (&dev_n))
    else $error("R1 select without a byte");
endmodule

// File: tb/spx_expander_tb.sv
module spx_expander_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] card_id;
  logic       sclk, sdi, setup_n, access_n;
  logic [8:0] ext_sel_n;
  logic [1:0] local_sel_n;

  always #2 clk = ~clk;

  spx_expander u_dut (
    .clk(clk), .rst_n(rst_n), .card_id(card_id), .sclk(sclk), .sdi(sdi),
    .setup_n(setup_n), .access_n(access_n),
    .ext_sel_n(ext_sel_n), .local_sel_n(local_sel_n)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    chk_on   = 0;
  bit    done     = 0;
  string phase    = "R1";

  // behavioural reference state
  int m_sh, m_cnt;
  bit m_ok, m_psclk, m_psetup;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = 0; m_cnt = 0; m_ok = 0; m_psclk = 0; m_psetup = 1;
    end else begin
      if (!setup_n) begin
        if (m_psetup) m_cnt = 0;
        if (sclk && !m_psclk) begin
          m_sh = ((m_sh << 1) | int'(sdi)) & 255;
          if (m_cnt < 8) m_cnt++;
        end
        m_ok = 0;
      end else if (!m_psetup) begin
        m_ok = (m_cnt == 8);
      end
      m_psclk  = sclk;
      m_psetup = setup_n;
    end
  end

  function automatic logic [10:0] model_sel();
    logic [10:0] v = '1;
    int idx = m_sh & 15;
    if (m_ok && setup_n && !access_n && ((m_sh >> 6) == int'(card_id)) && idx < 11)
      v[idx] = 1'b0;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [10:0] act, logic [10:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model, plus R10 at every cycle
  always @(negedge clk) begin
    if (chk_on && !done) begin
      check({local_sel_n, ext_sel_n} == model_sel(), phase,
            {local_sel_n, ext_sel_n}, model_sel());
      check($countones(~{local_sel_n, ext_sel_n}) <= 1, "R10",
            {local_sel_n, ext_sel_n}, model_sel());
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic probe(string req, logic [10:0] exp);
    @(negedge clk);
    check({local_sel_n, ext_sel_n} == exp, req, {local_sel_n, ext_sel_n}, exp);
  endtask

  task automatic send_bits(logic [15:0] v, int n);
    setup_n = 1'b0;
    tick(2);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i]; sclk = 1'b0; tick(2);
      sclk = 1'b1; tick(2);
    end
    sclk = 1'b0;
    tick(1);
    setup_n = 1'b1;
    tick(2);
  endtask

  function automatic logic [10:0] one_low(int i);
    logic [10:0] v = '1;
    if (i < 11) v[i] = 1'b0;
    return v;
  endfunction

  initial begin
    card_id = 2'b10; rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0;
    setup_n = 1'b1; access_n = 1'b1;
    tick(3);
    probe("R1", 11'h7FF);
    rst_n = 1'b1;
    tick(4);
    chk_on = 1;

    // R1: access before any byte selects nothing
    phase = "R1";
    access_n = 1'b0; tick(2); probe("R1", 11'h7FF); access_n = 1'b1; tick(1);

    // R4 / R5: sweep every index
    for (int i = 0; i < 16; i++) begin
      phase = (i < 11) ? "R4" : "R5";
      send_bits({8'h00, 2'b10, 2'b00, 4'(i)}, 8);
      access_n = 1'b0; tick(1);
      probe(phase, one_low(i));
      tick(2);
      access_n = 1'b1; tick(1);
      phase = "R6";
      probe("R6", 11'h7FF);
    end

    // R2: ignored middle bits and MSB-first order
    phase = "R2";
    send_bits({8'h00, 2'b10, 2'b11, 4'd3}, 8);
    access_n = 1'b0; tick(1); probe("R2", one_low(3)); access_n = 1'b1; tick(1);
    send_bits({8'h00, 2'b10, 2'b00, 4'd8}, 8);
    access_n = 1'b0; tick(1); probe("R2", one_low(8)); access_n = 1'b1; tick(1);

    // R3: other card fields
    phase = "R3";
    send_bits({8'h00, 2'b01, 2'b00, 4'd2}, 8);
    access_n = 1'b0; tick(1); probe("R3", 11'h7FF); access_n = 1'b1; tick(1);
    send_bits({8'h00, 2'b11, 2'b00, 4'd2}, 8);
    access_n = 1'b0; tick(1); probe("R3", 11'h7FF); access_n = 1'b1; tick(1);
    send_bits({8'h00, 2'b00, 2'b00, 4'd2}, 8);
    access_n = 1'b0; tick(1); probe("R3", 11'h7FF); access_n = 1'b1; tick(1);

    // R7: repeated strobes on one selection
    phase = "R7";
    send_bits({8'h00, 2'b10, 2'b00, 4'd5}, 8);
    for (int k = 0; k < 3; k++) begin
      access_n = 1'b0; tick(2); probe("R7", one_low(5));
      access_n = 1'b1; tick(2); probe("R7", 11'h7FF);
    end

    // R8: access held low across a whole setup period
    phase = "R8";
    access_n = 1'b0; setup_n = 1'b0; tick(2);
    probe("R8", 11'h7FF);
    send_bits({8'h00, 2'b10, 2'b00, 4'd6}, 8);
    probe("R8", one_low(6));
    access_n = 1'b1; tick(1);

    // R9: short byte drops the selection, long byte keeps last eight bits
    phase = "R9";
    send_bits({8'h00, 2'b10, 2'b00, 4'd4}, 8);
    send_bits(16'h0010, 5);
    access_n = 1'b0; tick(1); probe("R9", 11'h7FF); access_n = 1'b1; tick(1);
    send_bits(16'h0A87, 12);
    access_n = 1'b0; tick(1); probe("R9", one_low(7)); access_n = 1'b1; tick(1);

    tick(4);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule